// File: doc/BRIEF.md
# Per-CPU Pending Interrupt Selector

This block sits between an interrupt distributor's state and the CPU interfaces it serves. For every CPU interface it scans all interrupts that are pending, enabled and aimed at that CPU. It keeps only those whose group is enabled both globally and at the interface, and picks the one with the numerically smallest priority. That winner is published as the interface's pending ID only when it beats the interface's priority mask. It drives the interface's interrupt line only when it also beats the running priority. A group-0 winner may be routed to the fast line (FIQ) instead of the normal line (IRQ).

The block also holds the per-interrupt priority bytes. They have a secure view and a non-secure view. Non-secure software sees the group-1 priorities remapped into the lower half of the range and cannot touch group-0 priorities. An acknowledge port returns the ID a CPU would receive when it takes an interrupt at that moment.

The selection is combinational. Priority writes take effect on the next clock edge. The acknowledge result is registered one cycle after the request.

Top module: `psel_top`

## Requirements
- R1: When no interrupt qualifies for a CPU, or the winner fails the mask test, that CPU's pending ID is 1023 and its pending priority is 0xFF. Both are also the values after reset.
- R2: An interrupt qualifies for CPU c only if all of the following hold:
  - its pending bit is set;
  - its enable bit is set;
  - its target bit `irqTarget[c*NUM_IRQ+i]` is set;
  - the distributor enable for its group is set (`distEn[0]` group 0, `distEn[1]` group 1);
  - the interface enable for its group is set (`cpuEn[2c]` group 0, `cpuEn[2c+1]` group 1).
  
  The group is given by `irqGroup[i]`, where 0 means group 0 and 1 means group 1.
- R3: The winner becomes the pending ID only if its priority is strictly less than the CPU's priority mask ANDed with the truncation mask (0xF8 for 5 implemented bits).
- R4: The CPU's line (IRQ or FIQ) is high only if a pending ID is published and its priority is also strictly less than the 9-bit running priority. The running priority 0x100 means idle.
- R5: A group-0 winner drives FIQ when `cpuFiqEn[c]` is 1 and IRQ otherwise. A group-1 winner always drives IRQ. IRQ and FIQ are never high together.
- R6: The smallest priority value wins, and a tie goes to the lowest interrupt ID. Outputs follow input changes in the same cycle.
- R7: A secure priority write stores the data ANDed with the truncation mask. The new value is seen from the next cycle on. Writes to an index of NUM_IRQ or more are dropped.
- R8: A non-secure write to a group-1 interrupt stores (0x80 | data>>1) ANDed with the truncation mask. A non-secure write to a group-0 interrupt is ignored.
- R9: A secure read returns the stored byte. A non-secure read returns (stored<<1) & 0xFF for a group-1 interrupt and 0 for a group-0 interrupt. An index of NUM_IRQ or more reads 0.
- R10: One cycle after `ackReq`, `ackValid` is 1 for one cycle. `ackId` is then the requested CPU's pending ID if that ID's priority was below the running priority, and 1023 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqPending | input | NUM_IRQ | Pending bit per interrupt |
| irqEnable | input | NUM_IRQ | Enable bit per interrupt |
| irqGroup | input | NUM_IRQ | Group per interrupt (1 = group 1) |
| irqTarget | input | NUM_CPU*NUM_IRQ | Target bit, index c*NUM_IRQ+i |
| distEn | input | 2 | Distributor group enables |
| cpuEn | input | 2*NUM_CPU | Interface group enables, two per CPU |
| cpuFiqEn | input | NUM_CPU | Route group 0 to FIQ |
| cpuPmask | input | 8*NUM_CPU | Priority mask per CPU |
| cpuRunPrio | input | 9*NUM_CPU | Running priority per CPU |
| prioWrEn | input | 1 | Priority write strobe |
| prioWrNs | input | 1 | Write uses the non-secure view |
| prioWrIdx | input | 10 | Interrupt index to write |
| prioWrData | input | 8 | Priority write data |
| prioRdIdx | input | 10 | Interrupt index to read |
| prioRdNs | input | 1 | Read uses the non-secure view |
| prioRdData | output | 8 | Priority read data |
| ackReq | input | 1 | Acknowledge request |
| ackCpu | input | CPU_W | CPU of the acknowledge |
| ackValid | output | 1 | Acknowledge result valid |
| ackId | output | 10 | Acknowledged ID or 1023 |
| pendId | output | 10*NUM_CPU | Pending ID per CPU |
| pendPrio | output | 8*NUM_CPU | Pending priority per CPU |
| irqOut | output | NUM_CPU | IRQ line per CPU |
| fiqOut | output | NUM_CPU | FIQ line per CPU |

## Verification
A corrupted priority byte shows up at once on the read port. In the secure view it shows directly. In the non-secure view it shows shifted, and as a zero for group 0. Because selection is combinational, it also changes the pending ID or priority in the very cycle the bad value exists. A mistake in qualification or comparison shows the wrong ID, the wrong line, or IRQ and FIQ swapped on the same cycle as the input change. A stale acknowledge register shows one cycle after the request, as a wrong `ackId`.

// File: rtl/psel_pkg.sv
package psel_pkg;
  localparam int ID_W = 10;
  localparam int PRIO_W = 8;
  localparam int RUN_W = 9;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

  typedef struct packed {
    logic prioWrite;     // commit a priority write this cycle
    logic prioNsFormat;  // apply the non-secure remap to the data
    logic ackCapture;    // register an acknowledge result
  } selStrobe_t;
endpackage

// File: rtl/psel_ctrl.sv
module psel_ctrl
  import psel_pkg::*;
#(
  parameter int NUM_IRQ = 16
) (
  input  logic               prioWrEn,
  input  logic               prioWrNs,
  input  logic [ID_W-1:0]    prioWrIdx,
  input  logic [NUM_IRQ-1:0] irqGroup,
  input  logic               ackReq,
  output selStrobe_t         strobe
);
  logic idxHit;
  logic idxGroup;

  always_comb begin
    idxHit = 1'b0;
    idxGroup = 1'b0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (int'(prioWrIdx) == i) begin
        idxHit = 1'b1;
        idxGroup = irqGroup[i];
      end
    end
  end

  always_comb begin
    strobe = '0;
    // a non-secure write must not reach a group-0 byte
    strobe.prioWrite = prioWrEn && idxHit && (!prioWrNs || idxGroup);
    strobe.prioNsFormat = prioWrNs;
    strobe.ackCapture = ackReq;
  end
endmodule

// File: rtl/psel_arbiter.sv
module psel_arbiter
  import psel_pkg::*;
#(
  parameter int NUM_IRQ = 16,
  parameter int PRIO_BITS = 5,
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1,
  localparam int LOW_BITS = PRIO_W - PRIO_BITS,
  localparam logic [PRIO_W-1:0] TRUNC_MASK = PRIO_W'(32'hFF << LOW_BITS)
) (
  input  logic [NUM_IRQ-1:0]        candVec,
  input  logic [NUM_IRQ-1:0]        groupVec,
  input  logic [NUM_IRQ*PRIO_W-1:0] prioFlat,
  input  logic [1:0]                grpOk,
  input  logic [PRIO_W-1:0]         pmask,
  input  logic [RUN_W-1:0]          runPrio,
  input  logic                      fiqEn,
  output logic [ID_W-1:0]           pendId,
  output logic [PRIO_W-1:0]         pendPrio,
  output logic                      irqLine,
  output logic                      fiqLine
);
  logic              found;
  logic [IDX_W-1:0]  bestIdx;
  logic [PRIO_W-1:0] bestPrio;
  logic              bestGroup;
  logic [PRIO_W-1:0] pmaskEff;
  logic              pendValid;
  logic              lineOn;

  always_comb begin
    found = 1'b0;
    bestIdx = '0;
    bestPrio = '1;
    bestGroup = 1'b0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (candVec[i] && grpOk[groupVec[i]] &&
          (!found || prioFlat[i*PRIO_W +: PRIO_W] < bestPrio)) begin
        found = 1'b1;
        bestIdx = IDX_W'(i);
        bestPrio = prioFlat[i*PRIO_W +: PRIO_W];
        bestGroup = groupVec[i];
      end
    end
  end

  assign pmaskEff = pmask & TRUNC_MASK;
  assign pendValid = found && (bestPrio < pmaskEff);
  assign lineOn = pendValid && ({1'b0, bestPrio} < runPrio);

  always_comb begin
    if (pendValid) begin
      pendId = ID_W'(bestIdx);
      pendPrio = bestPrio;
    end else begin
      pendId = SPURIOUS_ID;
      pendPrio = '1;
    end
  end

  assign fiqLine = lineOn && !bestGroup && fiqEn;
  assign irqLine = lineOn && !(!bestGroup && fiqEn);
endmodule

// File: rtl/psel_datapath.sv
module psel_datapath
  import psel_pkg::*;
#(
  parameter int NUM_IRQ = 16,
  parameter int NUM_CPU = 2,
  parameter int PRIO_BITS = 5,
  localparam int CPU_W = $clog2(NUM_CPU + 1),
  localparam int LOW_BITS = PRIO_W - PRIO_BITS,
  localparam logic [PRIO_W-1:0] TRUNC_MASK = PRIO_W'(32'hFF << LOW_BITS)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  selStrobe_t                  strobe,
  input  logic [NUM_IRQ-1:0]          irqPending,
  input  logic [NUM_IRQ-1:0]          irqEnable,
  input  logic [NUM_IRQ-1:0]          irqGroup,
  input  logic [NUM_CPU*NUM_IRQ-1:0]  irqTarget,
  input  logic [1:0]                  distEn,
  input  logic [2*NUM_CPU-1:0]        cpuEn,
  input  logic [NUM_CPU-1:0]          cpuFiqEn,
  input  logic [PRIO_W*NUM_CPU-1:0]   cpuPmask,
  input  logic [RUN_W*NUM_CPU-1:0]    cpuRunPrio,
  input  logic [ID_W-1:0]             prioWrIdx,
  input  logic [PRIO_W-1:0]           prioWrData,
  input  logic [ID_W-1:0]             prioRdIdx,
  input  logic                        prioRdNs,
  output logic [PRIO_W-1:0]           prioRdData,
  input  logic [CPU_W-1:0]            ackCpu,
  output logic                        ackValid,
  output logic [ID_W-1:0]             ackId,
  output logic [ID_W*NUM_CPU-1:0]     pendId,
  output logic [PRIO_W*NUM_CPU-1:0]   pendPrio,
  output logic [NUM_CPU-1:0]          irqOut,
  output logic [NUM_CPU-1:0]          fiqOut
);
  logic [NUM_IRQ*PRIO_W-1:0] prioStore;
  logic [PRIO_W-1:0]         wrValue;
  logic [ID_W-1:0]           ackPick;

  // non-secure data lands in the lower half of the priority range
  assign wrValue = (strobe.prioNsFormat ? (8'h80 | (prioWrData >> 1)) : prioWrData)
                   & TRUNC_MASK;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_prio
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        prioStore[i*PRIO_W +: PRIO_W] <= '0;
      end else if (strobe.prioWrite && int'(prioWrIdx) == i) begin
        prioStore[i*PRIO_W +: PRIO_W] <= wrValue;
      end
    end
  end

  always_comb begin
    prioRdData = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (int'(prioRdIdx) == i) begin
        if (!prioRdNs) begin
          prioRdData = prioStore[i*PRIO_W +: PRIO_W];
        end else if (irqGroup[i]) begin
          prioRdData = PRIO_W'({prioStore[i*PRIO_W +: PRIO_W], 1'b0});
        end
      end
    end
  end

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [NUM_IRQ-1:0] candVec;
    logic [1:0]         grpOk;

    assign candVec = irqPending & irqEnable & irqTarget[c*NUM_IRQ +: NUM_IRQ];
    assign grpOk = distEn & cpuEn[2*c +: 2];

    psel_arbiter #(
      .NUM_IRQ(NUM_IRQ),
      .PRIO_BITS(PRIO_BITS)
    ) arb_i (
      .candVec (candVec),
      .groupVec(irqGroup),
      .prioFlat(prioStore),
      .grpOk   (grpOk),
      .pmask   (cpuPmask[c*PRIO_W +: PRIO_W]),
      .runPrio (cpuRunPrio[c*RUN_W +: RUN_W]),
      .fiqEn   (cpuFiqEn[c]),
      .pendId  (pendId[c*ID_W +: ID_W]),
      .pendPrio(pendPrio[c*PRIO_W +: PRIO_W]),
      .irqLine (irqOut[c]),
      .fiqLine (fiqOut[c])
    );
  end

  // a line is raised exactly when the pending ID beats the running priority
  always_comb begin
    ackPick = SPURIOUS_ID;
    for (int c = 0; c < NUM_CPU; c++) begin
      if (int'(ackCpu) == c && (irqOut[c] || fiqOut[c])) begin
        ackPick = pendId[c*ID_W +: ID_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackValid <= 1'b0;
      ackId <= SPURIOUS_ID;
    end else begin
      ackValid <= strobe.ackCapture;
      if (strobe.ackCapture) begin
        ackId <= ackPick;
      end
    end
  end
endmodule

// File: rtl/psel_top.sv
module psel_top
  import psel_pkg::*;
#(
  parameter int NUM_IRQ = 16,
  parameter int NUM_CPU = 2,
  parameter int PRIO_BITS = 5,
  localparam int CPU_W = $clog2(NUM_CPU + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_IRQ-1:0]          irqPending,
  input  logic [NUM_IRQ-1:0]          irqEnable,
  input  logic [NUM_IRQ-1:0]          irqGroup,
  input  logic [NUM_CPU*NUM_IRQ-1:0]  irqTarget,
  input  logic [1:0]                  distEn,
  input  logic [2*NUM_CPU-1:0]        cpuEn,
  input  logic [NUM_CPU-1:0]          cpuFiqEn,
  input  logic [8*NUM_CPU-1:0]        cpuPmask,
  input  logic [9*NUM_CPU-1:0]        cpuRunPrio,
  input  logic                        prioWrEn,
  input  logic                        prioWrNs,
  input  logic [9:0]                  prioWrIdx,
  input  logic [7:0]                  prioWrData,
  input  logic [9:0]                  prioRdIdx,
  input  logic                        prioRdNs,
  output logic [7:0]                  prioRdData,
  input  logic                        ackReq,
  input  logic [CPU_W-1:0]            ackCpu,
  output logic                        ackValid,
  output logic [9:0]                  ackId,
  output logic [10*NUM_CPU-1:0]       pendId,
  output logic [8*NUM_CPU-1:0]        pendPrio,
  output logic [NUM_CPU-1:0]          irqOut,
  output logic [NUM_CPU-1:0]          fiqOut
);
  selStrobe_t strobe;

  psel_ctrl #(.NUM_IRQ(NUM_IRQ)) ctrl_i (
    .prioWrEn (prioWrEn),
    .prioWrNs (prioWrNs),
    .prioWrIdx(prioWrIdx),
    .irqGroup (irqGroup),
    .ackReq   (ackReq),
    .strobe   (strobe)
  );

  psel_datapath #(
    .NUM_IRQ(NUM_IRQ),
    .NUM_CPU(NUM_CPU),
    .PRIO_BITS(PRIO_BITS)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .irqPending(irqPending),
    .irqEnable (irqEnable),
    .irqGroup  (irqGroup),
    .irqTarget (irqTarget),
    .distEn    (distEn),
    .cpuEn     (cpuEn),
    .cpuFiqEn  (cpuFiqEn),
    .cpuPmask  (cpuPmask),
    .cpuRunPrio(cpuRunPrio),
    .prioWrIdx (prioWrIdx),
    .prioWrData(prioWrData),
    .prioRdIdx (prioRdIdx),
    .prioRdNs  (prioRdNs),
    .prioRdData(prioRdData),
    .ackCpu    (ackCpu),
    .ackValid  (ackValid),
    .ackId     (ackId),
    .pendId    (pendId),
    .pendPrio  (pendPrio),
    .irqOut    (irqOut),
    .fiqOut    (fiqOut)
  );
endmodule

// File: rtl/psel_checker.sv
module psel_checker #(
  parameter int NUM_CPU = 2,
  parameter int PRIO_BITS = 5,
  localparam int CPU_W = $clog2(NUM_CPU + 1),
  localparam logic [7:0] TRUNC_MASK = 8'(32'hFF << (8 - PRIO_BITS))
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [NUM_CPU-1:0]    cpuFiqEn,
  input logic [8*NUM_CPU-1:0]  cpuPmask,
  input logic [9*NUM_CPU-1:0]  cpuRunPrio,
  input logic                  ackReq,
  input logic [CPU_W-1:0]      ackCpu,
  input logic                  ackValid,
  input logic [9:0]            ackId,
  input logic [10*NUM_CPU-1:0] pendId,
  input logic [8*NUM_CPU-1:0]  pendPrio,
  input logic [NUM_CPU-1:0]    irqOut,
  input logic [NUM_CPU-1:0]    fiqOut
);
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
    p_spurious_prio_r1: assert property (@(posedge clk) disable iff (!rstN)
      pendId[c*10 +: 10] == 10'd1023 |-> pendPrio[c*8 +: 8] == 8'hFF);

    p_beats_mask_r3: assert property (@(posedge clk) disable iff (!rstN)
      pendId[c*10 +: 10] != 10'd1023 |->
        pendPrio[c*8 +: 8] < (cpuPmask[c*8 +: 8] & TRUNC_MASK));

    p_line_needs_run_r4: assert property (@(posedge clk) disable iff (!rstN)
      (irqOut[c] || fiqOut[c]) |->
        (pendId[c*10 +: 10] != 10'd1023 &&
         {1'b0, pendPrio[c*8 +: 8]} < cpuRunPrio[c*9 +: 9]));

    p_one_line_r5: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0({irqOut[c], fiqOut[c]}));

    p_fiq_enabled_r5: assert property (@(posedge clk) disable iff (!rstN)
      fiqOut[c] |-> cpuFiqEn[c]);

    p_ack_taken_r10: assert property (@(posedge clk) disable iff (!rstN)
      (ackReq && int'(ackCpu) == c && (irqOut[c] || fiqOut[c])) |=>
        (ackValid && ackId == $past(pendId[c*10 +: 10])));

    p_ack_spurious_r10: assert property (@(posedge clk) disable iff (!rstN)
      (ackReq && int'(ackCpu) == c && !irqOut[c] && !fiqOut[c]) |=>
        (ackValid && ackId == 10'd1023));
  end

  p_ack_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    !ackReq |=> !ackValid);
endmodule

bind psel_top psel_checker #(.NUM_CPU(NUM_CPU), .PRIO_BITS(PRIO_BITS)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .cpuFiqEn  (cpuFiqEn),
  .cpuPmask  (cpuPmask),
  .cpuRunPrio(cpuRunPrio),
  .ackReq    (ackReq),
  .ackCpu    (ackCpu),
  .ackValid  (ackValid),
  .ackId     (ackId),
  .pendId    (pendId),
  .pendPrio  (pendPrio),
  .irqOut    (irqOut),
  .fiqOut    (fiqOut)
);

// File: tb/psel_top_tb_top.sv
module psel_top_tb_top;
  localparam int NUM_IRQ = 16;
  localparam int NUM_CPU = 2;
  localparam int CPU_W = $clog2(NUM_CPU + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NUM_IRQ-1:0] irqPending = '0;
  logic [NUM_IRQ-1:0] irqEnable = '0;
  logic [NUM_IRQ-1:0] irqGroup = '0;
  logic [NUM_CPU*NUM_IRQ-1:0] irqTarget = '0;
  logic [1:0] distEn = '0;
  logic [2*NUM_CPU-1:0] cpuEn = '0;
  logic [NUM_CPU-1:0] cpuFiqEn = '0;
  logic [8*NUM_CPU-1:0] cpuPmask = {NUM_CPU{8'hFF}};
  logic [9*NUM_CPU-1:0] cpuRunPrio = {NUM_CPU{9'h100}};
  logic prioWrEn = 1'b0;
  logic prioWrNs = 1'b0;
  logic [9:0] prioWrIdx = '0;
  logic [7:0] prioWrData = '0;
  logic [9:0] prioRdIdx = '0;
  logic prioRdNs = 1'b0;
  logic [7:0] prioRdData;
  logic ackReq = 1'b0;
  logic [CPU_W-1:0] ackCpu = '0;
  logic ackValid;
  logic [9:0] ackId;
  logic [10*NUM_CPU-1:0] pendId;
  logic [8*NUM_CPU-1:0] pendPrio;
  logic [NUM_CPU-1:0] irqOut;
  logic [NUM_CPU-1:0] fiqOut;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  psel_top #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .PRIO_BITS(5)) dut_i (.*);

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic writePrio(input int idx, input int val, input bit ns);
    @(negedge clk);
    prioWrEn = 1'b1; prioWrNs = ns; prioWrIdx = 10'(idx); prioWrData = 8'(val);
    @(negedge clk);
    prioWrEn = 1'b0;
  endtask

  task automatic readPrio(input int idx, input bit ns, output int val);
    prioRdIdx = 10'(idx); prioRdNs = ns;
    #1 val = int'(prioRdData);
  endtask

  task automatic t_reset();
    chk("R1 reset pendId cpu0", int'(pendId[9:0]), 1023);
    chk("R1 reset pendId cpu1", int'(pendId[19:10]), 1023);
    chk("R1 reset pendPrio cpu0", int'(pendPrio[7:0]), 8'hFF);
    chk("R4 reset lines", int'({irqOut, fiqOut}), 0);
    chk("R10 reset ackValid", int'(ackValid), 0);
  endtask

  task automatic t_select();
    writePrio(3, 8'h40, 1'b0);
    writePrio(5, 8'h40, 1'b0);
    writePrio(7, 8'h60, 1'b0);
    @(negedge clk);
    irqPending = 16'h00A8; irqEnable = 16'h00A8; irqGroup = 16'hFFFF;
    irqTarget[15:0] = 16'h00A8; distEn = 2'b11; cpuEn = 4'b1111;
    #1;
    chk("R6 tie to lowest id", int'(pendId[9:0]), 3);
    chk("R6 winner priority", int'(pendPrio[7:0]), 8'h40);
    chk("R4 irq raised", int'(irqOut[0]), 1);
    chk("R2 untargeted cpu1", int'(pendId[19:10]), 1023);
  endtask

  task automatic t_qualify();
    @(negedge clk); irqEnable[3] = 1'b0; #1;
    chk("R2 disabled skipped", int'(pendId[9:0]), 5);
    @(negedge clk); irqEnable[3] = 1'b1; distEn = 2'b01; #1;
    chk("R2 dist group1 off", int'(pendId[9:0]), 1023);
    chk("R1 spurious prio", int'(pendPrio[7:0]), 8'hFF);
    @(negedge clk); distEn = 2'b11; cpuEn[1] = 1'b0; #1;
    chk("R2 iface group1 off", int'(pendId[9:0]), 1023);
    @(negedge clk); cpuEn[1] = 1'b1; #1;
    chk("R2 restored", int'(pendId[9:0]), 3);
  endtask

  task automatic t_mask();
    @(negedge clk); cpuPmask[7:0] = 8'h47; #1;
    chk("R3 truncated mask equals prio", int'(pendId[9:0]), 1023);
    chk("R3 no line", int'(irqOut[0]), 0);
    @(negedge clk); cpuPmask[7:0] = 8'h48; #1;
    chk("R3 mask above prio", int'(pendId[9:0]), 3);
    @(negedge clk); cpuPmask[7:0] = 8'hFF;
  endtask

  task automatic t_running();
    @(negedge clk); cpuRunPrio[8:0] = 9'h040; #1;
    chk("R4 pending kept", int'(pendId[9:0]), 3);
    chk("R4 line held low", int'(irqOut[0]), 0);
    @(negedge clk); cpuRunPrio[8:0] = 9'h041; #1;
    chk("R4 line raised", int'(irqOut[0]), 1);
    @(negedge clk); cpuRunPrio[8:0] = 9'h100;
  endtask

  task automatic t_fiq();
    @(negedge clk); irqGroup[3] = 1'b0; cpuFiqEn[0] = 1'b1; #1;
    chk("R5 group0 to fiq", int'({irqOut[0], fiqOut[0]}), 1);
    @(negedge clk); cpuFiqEn[0] = 1'b0; #1;
    chk("R5 group0 to irq", int'({irqOut[0], fiqOut[0]}), 2);
    @(negedge clk); irqGroup[3] = 1'b1; cpuFiqEn[0] = 1'b1; #1;
    chk("R5 group1 stays irq", int'({irqOut[0], fiqOut[0]}), 2);
    @(negedge clk); irqGroup[3] = 1'b0; cpuFiqEn[0] = 1'b0;
  endtask

  task automatic t_views();
    int v;
    writePrio(9, 8'h47, 1'b0);
    readPrio(9, 1'b0, v);
    chk("R7 secure write truncated", v, 8'h40);
    writePrio(9, 8'h20, 1'b1);
    readPrio(9, 1'b0, v);
    chk("R8 ns write remapped", v, 8'h90);
    readPrio(9, 1'b1, v);
    chk("R9 ns read shifted", v, 8'h20);
    writePrio(3, 8'h10, 1'b1);
    readPrio(3, 1'b0, v);
    chk("R8 ns write group0 ignored", v, 8'h40);
    chk("R8 selection unchanged", int'(pendPrio[7:0]), 8'h40);
    readPrio(3, 1'b1, v);
    chk("R9 ns read group0 zero", v, 0);
    writePrio(20, 8'h00, 1'b0);
    readPrio(20, 1'b0, v);
    chk("R9 out of range reads 0", v, 0);
  endtask

  task automatic t_ack();
    @(negedge clk); ackReq = 1'b1; ackCpu = '0;
    @(negedge clk); ackReq = 1'b0;
    chk("R10 ack valid", int'(ackValid), 1);
    chk("R10 ack id taken", int'(ackId), 3);
    @(negedge clk);
    chk("R10 ack pulse ends", int'(ackValid), 0);
    cpuRunPrio[8:0] = 9'h040; ackReq = 1'b1;
    @(negedge clk); ackReq = 1'b0;
    chk("R10 ack below running", int'(ackId), 1023);
    cpuRunPrio[8:0] = 9'h100; ackReq = 1'b1; ackCpu = CPU_W'(1);
    @(negedge clk); ackReq = 1'b0;
    chk("R10 ack idle cpu1", int'(ackId), 1023);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 t_reset();
    rstN = 1'b1;
    t_select();
    t_qualify();
    t_mask();
    t_running();
    t_fiq();
    t_views();
    t_ack();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end
endmodule